// File: doc/BRIEF.md
# Byte-Wide Serial Port with Bus Register Interface

This block is a byte-wide asynchronous serial port that sits on a Wishbone slave port with a 12-bit address and 8-bit data. Software writes bytes into a transmit queue and a serializer sends them as 8N1 frames. A deserializer collects incoming frames into a receive queue, which software drains by reading a data register. Both serial engines share one oversampling tick. The tick's rate comes from a programmable 8-bit divisor.

A status register reports whether each queue is empty or full. Two enable bits decide which queue conditions drive a single level interrupt. The bus handshake holds its acknowledge for as long as the master keeps the strobe high. Each register access therefore takes effect exactly once, however long the master stretches the cycle.

Top module: `wb_serial_port`

## Requirements
- R1: A write to offset 0x000 places the data byte at the tail of the transmit queue. A read of offset 0x008 returns the oldest received byte and removes it from the receive queue.
- R2: A read of offset 0x010 returns the status byte. Bit 0 is receive queue empty, bit 1 is transmit queue empty, bit 2 is receive queue full, bit 3 is transmit queue full, and bits 7..4 read as zero.
- R3: Offset 0x020 holds two enable bits and reads back with its upper six bits zero. The interrupt output is high while (bit 0 set and receive queue not empty) or (bit 1 set and transmit queue empty).
- R4: Offset 0x018 is an 8-bit divisor register that reads back the last value written. The oversampling tick occurs once every divisor+1 clocks, and one serial bit lasts 16 ticks.
- R5: When the port is idle and cyc and stb are both high, it accepts one access. The acknowledge appears in the next cycle and stays high while stb remains high. The port goes idle in the cycle after stb falls, and no access repeats while the acknowledge is held.
- R6: The acknowledge output is the held acknowledge gated by both cyc and stb, so it falls at once when either input drops.
- R7: A read of any other offset returns zero. A write to any other offset is acknowledged and changes nothing.
- R8: After reset the divisor and both enables are zero, the acknowledge is low, the port is idle, the serial output is high and the interrupt is low.
- R9: The serial output idles high. Each byte is sent as one low start bit, eight data bits with the LSB first, and one high stop bit.
- R10: The receiver confirms a start bit by sampling the line again at its middle. A low pulse shorter than half a bit is ignored. Data bits are sampled at their middle, and a frame whose stop bit samples high is pushed into the receive queue.
- R11: The queue depth is a parameter with a default of 64. A write to the transmit register while the transmit queue is full is discarded.
- R12: A read of the receive register while the receive queue is empty returns zero and leaves the queue unchanged. A frame that completes while the receive queue is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_tx_o | output | 1 | Serial transmit line |
| ser_rx_i | input | 1 | Serial receive line (asynchronous) |
| intr_o | output | 1 | Level interrupt |
| wb_adr_i | input | 12 | Register byte address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data |
| wb_we_i | input | 1 | Write enable |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_ack_o | output | 1 | Acknowledge |

## Verification
The two overflow paths are the hardest states to reach. The transmit-full drop needs 66 queued writes to land before the serializer finishes its first frame. The bench therefore issues back-to-back two-cycle writes at the fastest divisor, so that 65 bytes are accepted inside one 160-clock frame time. It then decodes every frame on the line to show that the 66th byte never appears. The receive-full drop is reached by driving 65 complete frames with no reads in between. The bench then drains the queue and checks that the last frame was the one discarded.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int ADR_W = 12;
  localparam int DAT_W = 8;
  localparam int OVS   = 16;

  localparam logic [ADR_W-1:0] OFS_TXQ  = 12'h000;
  localparam logic [ADR_W-1:0] OFS_RXQ  = 12'h008;
  localparam logic [ADR_W-1:0] OFS_STAT = 12'h010;
  localparam logic [ADR_W-1:0] OFS_DIV  = 12'h018;
  localparam logic [ADR_W-1:0] OFS_IEN  = 12'h020;

  typedef enum logic [1:0] {BUS_IDLE, BUS_WR_ACK, BUS_RD_ACK} bus_st_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic         do_wr, do_rd;

  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rptr_q[AW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_wr) wptr_d = wptr_q + 1'b1;
    if (do_rd) rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q[AW-1:0]] <= wdata;
  end

  // R11: a push into a full queue must leave the write pointer alone
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> $stable(wptr_q));
  // R12: a pop from an empty queue must leave the read pointer alone
  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd && !wr) |=> $stable(rptr_q));
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= div);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: the tick counter never runs past the divisor after a tick
  assert_tick_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          q_empty,
  input  logic [DW-1:0] q_data,
  output logic          q_pop,
  output logic          txd
);
  localparam int FRAME = DW + 2;
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FRAME);

  logic             busy_q, busy_d;
  logic [FRAME-1:0] sh_q, sh_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  assign txd = sh_q[0];

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    sub_d  = sub_q;
    bit_d  = bit_q;
    q_pop  = 1'b0;
    if (!busy_q) begin
      if (!q_empty) begin
        q_pop  = 1'b1;
        busy_d = 1'b1;
        sh_d   = {1'b1, q_data, 1'b0};
        sub_d  = '0;
        bit_d  = '0;
      end
    end else if (tick) begin
      if (sub_q == SUB_W'(OVS - 1)) begin
        sub_d = '0;
        sh_d  = {1'b1, sh_q[FRAME-1:1]};
        if (bit_q == BIT_W'(FRAME - 1)) busy_d = 1'b0;
        else                            bit_d  = bit_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      sub_q  <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      sub_q  <= sub_d;
      bit_q  <= bit_d;
    end
  end

  // R9: every frame opens with a low start bit
  assert_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd);
  // R9: the line rests high between frames
  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd);
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_async,
  output logic          push,
  output logic [DW-1:0] data
);
  import uart_pkg::*;
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DW);

  logic [1:0]       sync_q;
  logic             rx;
  rx_st_e           st_q, st_d;
  logic [SUB_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bits_q, bits_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic             push_q, push_d;

  assign rx   = sync_q[1];
  assign push = push_q;
  assign data = sh_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bits_d = bits_q;
    sh_d   = sh_q;
    push_d = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rx) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (cnt_q == SUB_W'(OVS/2 - 1)) begin
            st_d   = rx ? RX_IDLE : RX_DATA;
            cnt_d  = '0;
            bits_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == SUB_W'(OVS - 1)) begin
            cnt_d = '0;
            sh_d  = {rx, sh_q[DW-1:1]};
            if (bits_q == BIT_W'(DW - 1)) st_d = RX_STOP;
            else                          bits_d = bits_q + 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == SUB_W'(OVS - 1)) begin
            st_d   = RX_IDLE;
            cnt_d  = '0;
            push_d = rx;
          end else cnt_d = cnt_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bits_q <= '0;
      sh_q   <= '0;
      push_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_async};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bits_q <= bits_d;
      sh_q   <= sh_d;
      push_q <= push_d;
    end
  end

  // R10: a byte is delivered only on leaving the stop-bit state
  assert_push_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> ($past(st_q) == RX_STOP) && (st_q == RX_IDLE));
endmodule

// File: rtl/wb_serial_port.sv
module wb_serial_port #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        arst_n,
  output logic        ser_tx_o,
  input  logic        ser_rx_i,
  output logic        intr_o,
  input  logic [11:0] wb_adr_i,
  input  logic [7:0]  wb_dat_i,
  output logic [7:0]  wb_dat_o,
  input  logic        wb_we_i,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  output logic        wb_ack_o
);
  import uart_pkg::*;

  logic [1:0]       rs_q;
  logic             rst_n;
  bus_st_e          st_q, st_d;
  logic             ack_q, ack_d;
  logic [DAT_W-1:0] rdat_q, rdat_d, rd_mux;
  logic [DAT_W-1:0] div_q, div_d;
  logic [1:0]       ien_q, ien_d;
  logic             accept, wr_acc, rd_acc;
  logic             txq_push, rxq_pop;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [DAT_W-1:0] tx_head, rx_head, rx_byte;
  logic             tx_pop, rx_push, tick;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  assign accept   = (st_q == BUS_IDLE) && wb_cyc_i && wb_stb_i;
  assign wr_acc   = accept && wb_we_i;
  assign rd_acc   = accept && !wb_we_i;
  assign txq_push = wr_acc && (wb_adr_i == OFS_TXQ);
  assign rxq_pop  = rd_acc && (wb_adr_i == OFS_RXQ) && !rx_empty;

  always_comb begin
    case (wb_adr_i)
      OFS_RXQ:  rd_mux = rx_empty ? '0 : rx_head;
      OFS_STAT: rd_mux = {4'b0000, tx_full, rx_full, tx_empty, rx_empty};
      OFS_DIV:  rd_mux = div_q;
      OFS_IEN:  rd_mux = {6'b000000, ien_q};
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    ack_d  = ack_q;
    rdat_d = rdat_q;
    div_d  = div_q;
    ien_d  = ien_q;
    case (st_q)
      BUS_IDLE: begin
        if (accept) begin
          ack_d = 1'b1;
          st_d  = wb_we_i ? BUS_WR_ACK : BUS_RD_ACK;
          if (rd_acc) rdat_d = rd_mux;
          if (wr_acc && wb_adr_i == OFS_DIV) div_d = wb_dat_i;
          if (wr_acc && wb_adr_i == OFS_IEN) ien_d = wb_dat_i[1:0];
        end
      end
      default: begin
        if (!wb_stb_i) begin
          ack_d = 1'b0;
          st_d  = BUS_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BUS_IDLE;
      ack_q  <= 1'b0;
      rdat_q <= '0;
      div_q  <= '0;
      ien_q  <= '0;
    end else begin
      st_q   <= st_d;
      ack_q  <= ack_d;
      rdat_q <= rdat_d;
      div_q  <= div_d;
      ien_q  <= ien_d;
    end
  end

  assign wb_ack_o = ack_q && wb_cyc_i && wb_stb_i;
  assign wb_dat_o = rdat_q;
  assign intr_o   = (ien_q[0] && !rx_empty) || (ien_q[1] && tx_empty);

  tick_gen #(.DW(DAT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
  );

  byte_fifo #(.W(DAT_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .wr(txq_push), .wdata(wb_dat_i),
    .rd(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
  );

  byte_fifo #(.W(DAT_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .wr(rx_push), .wdata(rx_byte),
    .rd(rxq_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
  );

  uart_tx_ser #(.DW(DAT_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .q_empty(tx_empty),
    .q_data(tx_head), .q_pop(tx_pop), .txd(ser_tx_o)
  );

  uart_rx_deser #(.DW(DAT_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_async(ser_rx_i),
    .push(rx_push), .data(rx_byte)
  );

  // R5: an accepted access raises the held acknowledge next cycle
  assert_accept_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ack_q && (st_q != BUS_IDLE));
  // R5: the acknowledge is held while the strobe stays high
  assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && wb_stb_i) |=> ack_q);
  // R4: the divisor changes only through an accepted write to its offset
  assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && wb_adr_i == OFS_DIV) |=> $stable(div_q));
  // R7: writes to other offsets leave the enables unchanged
  assert_ien_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && wb_adr_i == OFS_IEN) |=> $stable(ien_q));
endmodule

// File: tb/tb_wb_serial_port.sv
`timescale 1ns/1ps
module tb_wb_serial_port;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        ser_tx, ser_rx, intr;
  logic [11:0] adr;
  logic [7:0]  wdat, rdat;
  logic        we, cyc, stb, ack;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  wb_serial_port dut (
    .clk(clk), .arst_n(arst_n), .ser_tx_o(ser_tx), .ser_rx_i(ser_rx),
    .intr_o(intr), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat),
    .wb_we_i(we), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_ack_o(ack)
  );

  // {we, address, write data, expected read data}
  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 12'h018, 8'h5A, 8'h00},
    {1'b0, 12'h018, 8'h00, 8'h5A},
    {1'b1, 12'h020, 8'hFF, 8'h00},
    {1'b0, 12'h020, 8'h00, 8'h03},
    {1'b0, 12'h028, 8'h00, 8'h00},
    {1'b1, 12'h030, 8'h77, 8'h00},
    {1'b0, 12'h018, 8'h00, 8'h5A},
    {1'b0, 12'h010, 8'h00, 8'h03},
    {1'b0, 12'h008, 8'h00, 8'h00},
    {1'b1, 12'h020, 8'h00, 8'h00},
    {1'b0, 12'h020, 8'h00, 8'h00},
    {1'b1, 12'h018, 8'h00, 8'h00}
  };

  function automatic string vec_req(input int i);
    case (i)
      1:       return "R4";
      3:       return "R3";
      4, 6:    return "R7";
      7:       return "R2";
      8:       return "R12";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [11:0] a, input logic [7:0] d,
                      output logic [7:0] q);
    @(negedge clk);
    we = w; adr = a; wdat = d; cyc = 1'b1; stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    q = rdat;
    cyc = 1'b0; stb = 1'b0;
    @(posedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input int bitclk);
    @(negedge clk); ser_rx = 1'b0;
    repeat (bitclk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      repeat (bitclk) @(negedge clk);
    end
    ser_rx = 1'b1;
    repeat (bitclk + 4) @(negedge clk);
  endtask

  // line monitor: decodes frames at 16 clocks per bit (divisor 0)
  logic [7:0] mon_buf [128];
  int         mon_cnt = 0;
  int         mon_ferr = 0;
  logic       mon_on = 1'b0;
  initial begin
    forever begin
      @(negedge ser_tx);
      if (mon_on) begin
        logic [7:0] b;
        repeat (8) @(posedge clk); #1;
        if (ser_tx !== 1'b0) mon_ferr++;
        for (int i = 0; i < 8; i++) begin
          repeat (16) @(posedge clk); #1;
          b[i] = ser_tx;
        end
        repeat (16) @(posedge clk); #1;
        if (ser_tx !== 1'b1) mon_ferr++;
        if (mon_cnt < 128) mon_buf[mon_cnt] = b;
        mon_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int errs;
    arst_n = 1'b0; ser_rx = 1'b1; adr = '0; wdat = '0;
    we = 1'b0; cyc = 1'b0; stb = 1'b0;
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset state at the ports
    chk("R8 intr", intr, 0);
    chk("R8 tx idle", ser_tx, 1);
    chk("R8 ack", ack, 0);
    xfer(0, 12'h018, 0, q); chk("R8 div", q, 8'h00);
    xfer(0, 12'h020, 0, q); chk("R8 ien", q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      xfer(v[28], v[27:16], v[15:8], q);
      if (!v[28]) chk(vec_req(i), q, v[7:0]);
    end

    // R5 / R6: hold the strobe, then release cyc before stb
    @(negedge clk);
    we = 0; adr = 12'h010; cyc = 1; stb = 1;
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R5 ack held", ack, 1);
    end
    cyc = 0;
    #0.5 chk("R6 ack gated by cyc", ack, 0);
    @(negedge clk); stb = 0;
    @(posedge clk);
    xfer(0, 12'h010, 0, q); chk("R5 next access after release", q, 8'h03);

    // R3: interrupt sources
    xfer(1, 12'h020, 8'h02, q);
    @(negedge clk); chk("R3 tx-ready irq", intr, 1);
    xfer(1, 12'h020, 8'h01, q);
    @(negedge clk); chk("R3 rx irq idle", intr, 0);

    // R1 / R10: receive at divisor 0
    send_rx(8'hA5, 16);
    chk("R3 rx irq set", intr, 1);
    xfer(0, 12'h010, 0, q); chk("R2 status rx ready", q, 8'h02);
    xfer(0, 12'h008, 0, q); chk("R1 rx byte", q, 8'hA5);
    xfer(0, 12'h010, 0, q); chk("R1 rx drained", q, 8'h03);
    @(negedge clk); chk("R3 rx irq clear", intr, 0);

    // R10: short low pulse is not a start bit
    @(negedge clk); ser_rx = 0;
    repeat (3) @(negedge clk); ser_rx = 1;
    repeat (200) @(negedge clk);
    xfer(0, 12'h010, 0, q); chk("R10 glitch ignored", q, 8'h03);

    // R4: divisor 3 gives 64 clocks per bit
    xfer(1, 12'h018, 8'h03, q);
    send_rx(8'h3C, 64);
    xfer(0, 12'h008, 0, q); chk("R4 rx at divisor 3", q, 8'h3C);
    xfer(1, 12'h018, 8'h00, q);

    // R9: one transmitted frame
    mon_on = 1; mon_cnt = 0; mon_ferr = 0;
    xfer(1, 12'h000, 8'h96, q);
    repeat (220) @(negedge clk);
    chk("R9 frame count", mon_cnt, 1);
    chk("R9 frame data", mon_buf[0], 8'h96);
    chk("R9 framing", mon_ferr, 0);

    // R11: 66 writes inside one frame time, the last must be dropped
    mon_cnt = 0; mon_ferr = 0;
    for (int i = 1; i <= 66; i++) xfer(1, 12'h000, 8'(i), q);
    xfer(0, 12'h010, 0, q); chk("R11 tx full status", q, 8'h09);
    repeat (66 * 160 + 300) @(negedge clk);
    chk("R11 frames sent", mon_cnt, 65);
    errs = 0;
    for (int i = 0; i < 65; i++) if (mon_buf[i] !== 8'(i + 1)) errs++;
    chk("R11 frame order", errs, 0);
    chk("R9 framing burst", mon_ferr, 0);
    mon_on = 0;

    // R12: fill receive queue, overflow frame discarded
    for (int i = 0; i < 64; i++) send_rx(8'(i) ^ 8'h5A, 16);
    xfer(0, 12'h010, 0, q); chk("R2 rx full status", q, 8'h06);
    send_rx(8'hEE, 16);
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      xfer(0, 12'h008, 0, q);
      if (q !== (8'(i) ^ 8'h5A)) errs++;
    end
    chk("R12 rx order after overflow", errs, 0);
    xfer(0, 12'h010, 0, q); chk("R12 rx empty after drain", q, 8'h03);
    xfer(0, 12'h008, 0, q); chk("R12 empty read zero", q, 8'h00);
    xfer(0, 12'h010, 0, q); chk("R12 empty read no change", q, 8'h03);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule